// File: doc/BRIEF.md
# Memory Line Integrity Check Controller

This block sits in the read/write path of a memory controller that serves protected memory. For every cache line it keeps a small metadata record: an owner bit (the line was last written through a private key ID), the key ID of the last writer, a 28-bit integrity tag, a sticky poison flag and an error-logged flag. Encryption, decryption and tag hashing happen elsewhere. The datapath hands this block the already-decrypted line data and the 28-bit tag it recomputed over that data, the owner bit and the address tweak. The block then decides whether the requester gets the data or all zeros, whether the line becomes poisoned, and whether an error-log event is raised.

Requests arrive on a valid/ready interface and each one gets exactly one registered response. Two integrity modes are selectable. In the cryptographic mode the owner bit and the tag are both checked. In the logical mode only the owner bit is checked. A key ID is classed as private when it is at or above a programmable threshold. Writes refresh the metadata, and only a write that covers the whole line clears poison. A saturating counter records how many error-log events have occurred.

Control is a two-state machine. `ST_IDLE` accepts a request (transition `T_ACCEPT`). `ST_RESP` presents the response for one cycle and then returns to `ST_IDLE` (transition `T_DONE`). Outside these transitions the machine stays in `ST_IDLE` (`T_WAIT`).

Top module: `line_integrity_ctl`

## Requirements
- R1: `req_ready` is 1 in the idle state. An accepted request (valid and ready at a rising edge) makes `rsp_valid` 1 for exactly the next cycle. `req_ready` is 0 during that cycle.
- R2: A key ID is private when `req_key >= cfg_priv_base` (unsigned) and shared otherwise.
- R3: Every write stores the requester's key ID and the supplied tag, and sets the owner bit to 1 for a private key or to 0 for a shared key. Only a write with `req_full`=1 clears the line's poison and error-logged flags. Every write response has zero data and all flags 0.
- R4: A read with a private key of a line whose owner bit is 0 returns zeros, sets `rsp_poison` and poisons the line. This holds in both modes.
- R5: A read with a private key of a line whose owner bit is 1 returns zeros and poisons the line when the stored key ID differs from the requester's, or when the mode is cryptographic and the tags differ. Otherwise it returns `req_data`. In the logical mode the tag is ignored.
- R6: In the cryptographic mode (`cfg_mode`=0), a read with a shared key of a line with owner bit 1 returns zeros and poisons the line. With owner bit 0, the read returns zeros and poisons the line if the tags differ, and returns `req_data` if they match.
- R7: In the logical mode (`cfg_mode`=1), a read with a shared key of a line with owner bit 1 returns zeros with `rsp_err`=1 and `rsp_poison`=0, and sets the line's error-logged flag. With owner bit 0 the read returns `req_data` whatever the tag.
- R8: A read of a poisoned line returns zeros with `rsp_poison`=1 and performs no other check. A partial write leaves the line poisoned.
- R9: A read with `req_secure`=0 of an unpoisoned line with owner bit 1 returns zeros, with `rsp_poison`=0 and `rsp_err`=0, and leaves the metadata unchanged.
- R10: A read of a line whose error-logged flag is set returns `rsp_mce`=1 in its response.
- R11: `err_count` increments by one with each `rsp_err` response and holds at its maximum (15 by default).
- R12: After reset every line has owner 0, key 0, tag 0 and no flags, `err_count` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | 0 cryptographic integrity, 1 logical integrity |
| cfg_priv_base | input | KEY_W | Lowest private key ID |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_full | input | 1 | Write covers the whole line |
| req_line | input | IDX_W | Line index |
| req_key | input | KEY_W | Requester key ID |
| req_secure | input | 1 | Requester runs in the secure execution mode |
| req_tag | input | TAG_W | Tag to store (write) or recomputed tag (read) |
| req_data | input | DATA_W | Decrypted line data for a read |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_data | output | DATA_W | Data or zeros |
| rsp_poison | output | 1 | Line is or has just become poisoned |
| rsp_err | output | 1 | Error-log event pulse |
| rsp_mce | output | 1 | Read hit a line with a logged error |
| err_count | output | CNT_W | Saturating count of error-log events |

## Verification
The bench goes after the borders of the decision table. It drives a key exactly at and one below the private threshold. It aims a tag mismatch at the logical mode, where a design that checked tags there would zero good data. It reads with a foreign private key, which a design tracking only the owner bit would let through. It reads a poisoned line after a partial write, which a design clearing poison on every write would answer with live data. It also reads private lines from a non-secure requester, where wrongly setting poison or an error would corrupt later reads. Finally it repeats logical-mode shared reads past the counter limit, where a wrapping counter would return to zero.

// File: rtl/lic_pkg.sv
package lic_pkg;

    typedef enum logic [2:0] {
        V_PASS,
        V_POISONED,
        V_NEW_POISON,
        V_NONSECURE,
        V_ERRLOG,
        V_WRITE
    } verdict_e;

    typedef enum logic {
        MODE_CRYPTO  = 1'b0,
        MODE_LOGICAL = 1'b1
    } integ_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } ctl_state_e;

endpackage

// File: rtl/lic_meta_store.sv
module lic_meta_store #(
    parameter int LINES = 16,
    parameter int KEY_W = 6,
    parameter int TAG_W = 28,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_owner,
    output logic [KEY_W-1:0] rd_key,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_poison,
    output logic             rd_errf,
    input  logic             upd_write,
    input  logic             upd_full,
    input  logic             upd_set_poison,
    input  logic             upd_set_err,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             wr_owner,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [TAG_W-1:0] wr_tag
);

    logic             owner_q  [LINES];
    logic [KEY_W-1:0] key_q    [LINES];
    logic [TAG_W-1:0] tag_q    [LINES];
    logic             poison_q [LINES];
    logic             errf_q   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic hit;
        assign hit = (upd_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                owner_q[g]  <= 1'b0;
                key_q[g]    <= '0;
                tag_q[g]    <= '0;
                poison_q[g] <= 1'b0;
                errf_q[g]   <= 1'b0;
            end else if (hit) begin
                if (upd_write) begin
                    owner_q[g] <= wr_owner;
                    key_q[g]   <= wr_key;
                    tag_q[g]   <= wr_tag;
                    if (upd_full) begin
                        poison_q[g] <= 1'b0;
                        errf_q[g]   <= 1'b0;
                    end
                end else begin
                    if (upd_set_poison) poison_q[g] <= 1'b1;
                    if (upd_set_err)    errf_q[g]   <= 1'b1;
                end
            end
        end
    end

    assign rd_owner  = owner_q[rd_idx];
    assign rd_key    = key_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_poison = poison_q[rd_idx];
    assign rd_errf   = errf_q[rd_idx];

endmodule

// File: rtl/lic_decide.sv
module lic_decide
    import lic_pkg::*;
#(
    parameter int KEY_W = 6,
    parameter int TAG_W = 28
) (
    input  integ_mode_e      mode,
    input  logic             is_write,
    input  logic             key_private,
    input  logic             secure,
    input  logic [KEY_W-1:0] req_key,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             m_owner,
    input  logic [KEY_W-1:0] m_key,
    input  logic [TAG_W-1:0] m_tag,
    input  logic             m_poison,
    output verdict_e         verdict
);

    logic tag_bad;
    logic key_bad;

    assign tag_bad = (req_tag != m_tag);
    assign key_bad = (req_key != m_key);

    always_comb begin
        verdict = V_PASS;
        if (is_write) begin
            verdict = V_WRITE;
        end else if (m_poison) begin
            verdict = V_POISONED;
        end else if (m_owner && !secure) begin
            verdict = V_NONSECURE;
        end else if (key_private) begin
            if (!m_owner) begin
                verdict = V_NEW_POISON;
            end else if (key_bad || (mode == MODE_CRYPTO && tag_bad)) begin
                verdict = V_NEW_POISON;
            end
        end else begin
            if (m_owner) begin
                verdict = (mode == MODE_CRYPTO) ? V_NEW_POISON : V_ERRLOG;
            end else if (mode == MODE_CRYPTO && tag_bad) begin
                verdict = V_NEW_POISON;
            end
        end
    end

endmodule

// File: rtl/line_integrity_ctl.sv
module line_integrity_ctl
    import lic_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int KEY_W  = 6,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic [KEY_W-1:0]  cfg_priv_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_full,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [KEY_W-1:0]  req_key,
    input  logic              req_secure,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_poison,
    output logic              rsp_err,
    output logic              rsp_mce,
    output logic [CNT_W-1:0]  err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ctl_state_e state_q, state_d;
    logic       accept;
    logic       key_private;
    verdict_e   verdict;

    logic             m_owner;
    logic [KEY_W-1:0] m_key;
    logic [TAG_W-1:0] m_tag;
    logic             m_poison;
    logic             m_errf;

    assign accept      = req_valid && req_ready;
    assign key_private = (req_key >= cfg_priv_base);

    lic_meta_store #(
        .LINES (LINES),
        .KEY_W (KEY_W),
        .TAG_W (TAG_W)
    ) u_meta (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_idx         (req_line),
        .rd_owner       (m_owner),
        .rd_key         (m_key),
        .rd_tag         (m_tag),
        .rd_poison      (m_poison),
        .rd_errf        (m_errf),
        .upd_write      (accept && req_write),
        .upd_full       (req_full),
        .upd_set_poison (accept && (verdict == V_NEW_POISON)),
        .upd_set_err    (accept && (verdict == V_ERRLOG)),
        .upd_idx        (req_line),
        .wr_owner       (key_private),
        .wr_key         (req_key),
        .wr_tag         (req_tag)
    );

    lic_decide #(
        .KEY_W (KEY_W),
        .TAG_W (TAG_W)
    ) u_decide (
        .mode        (integ_mode_e'(cfg_mode)),
        .is_write    (req_write),
        .key_private (key_private),
        .secure      (req_secure),
        .req_key     (req_key),
        .req_tag     (req_tag),
        .m_owner     (m_owner),
        .m_key       (m_key),
        .m_tag       (m_tag),
        .m_poison    (m_poison),
        .verdict     (verdict)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_ACCEPT, T_DONE, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // Registered response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data   <= '0;
            rsp_poison <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_mce    <= 1'b0;
            err_count  <= '0;
        end else if (accept) begin
            rsp_data   <= (verdict == V_PASS) ? req_data : '0;
            rsp_poison <= (verdict == V_POISONED) || (verdict == V_NEW_POISON);
            rsp_err    <= (verdict == V_ERRLOG);
            rsp_mce    <= !req_write && m_errf;
            if (verdict == V_ERRLOG && err_count != CNT_MAX)
                err_count <= err_count + 1'b1;
        end else begin
            rsp_err <= 1'b0;
            rsp_mce <= 1'b0;
        end
    end

endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_poison,
    input logic              rsp_err,
    input logic [CNT_W-1:0]  err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_rsp_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_single_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_fail_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_poison || rsp_err)) |-> (rsp_data == '0));

    assert_err_not_poison_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_poison);

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (err_count == $past(err_count) + 1'b1 || err_count == CNT_MAX));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX) |=> (err_count == CNT_MAX));

    assert_cnt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_err |-> (err_count == $past(err_count)));

endmodule

bind line_integrity_ctl lic_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_lic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_poison (rsp_poison),
    .rsp_err    (rsp_err),
    .err_count  (err_count)
);

// File: tb/tb_line_integrity_ctl.sv
module tb_line_integrity_ctl;

    localparam int LINES = 16, KEY_W = 6, TAG_W = 28, DATA_W = 32, CNT_W = 4;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_mode = 1'b0;
    logic [KEY_W-1:0]  cfg_priv_base = 6'd32;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_full = 1'b0;
    logic [IDX_W-1:0]  req_line = '0;
    logic [KEY_W-1:0]  req_key = '0;
    logic              req_secure = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_poison, rsp_err, rsp_mce;
    logic [CNT_W-1:0]  err_count;

    always #2.5 clk = ~clk;

    line_integrity_ctl dut (.*);

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              poison;
        logic              err;
        logic              mce;
        int                cnt;
        string             rq;
    } exp_t;

    exp_t exp_q[$];
    int total = 0, bad = 0;
    bit finished = 0;

    // Reference state per line
    bit      m_own  [LINES];
    int      m_key  [LINES];
    int      m_tag  [LINES];
    bit      m_pois [LINES];
    bit      m_errf [LINES];
    int      m_cnt = 0;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(bit wr, bit full, int line, int key, bit sec,
                          int tag, int data, string rq);
        exp_t e;
        bit priv;
        priv = (key >= int'(cfg_priv_base));
        e.data = '0; e.poison = 0; e.err = 0; e.mce = 0; e.rq = rq;
        if (wr) begin
            m_own[line] = priv;
            m_key[line] = key;
            m_tag[line] = tag;
            if (full) begin
                m_pois[line] = 0;
                m_errf[line] = 0;
            end
        end else begin
            e.mce = m_errf[line];
            if (m_pois[line]) begin
                e.poison = 1;
            end else if (m_own[line] && !sec) begin
                e.poison = 0;
            end else if (priv) begin
                if (!m_own[line] || m_key[line] != key ||
                    (cfg_mode == 1'b0 && m_tag[line] != tag)) begin
                    e.poison = 1; m_pois[line] = 1;
                end else e.data = data;
            end else begin
                if (m_own[line]) begin
                    if (cfg_mode == 1'b0) begin
                        e.poison = 1; m_pois[line] = 1;
                    end else begin
                        e.err = 1; m_errf[line] = 1;
                        if (m_cnt < 15) m_cnt++;
                    end
                end else if (cfg_mode == 1'b0 && m_tag[line] != tag) begin
                    e.poison = 1; m_pois[line] = 1;
                end else e.data = data;
            end
        end
        e.cnt = m_cnt;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready_idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_full = full;
        req_line = IDX_W'(line); req_key = KEY_W'(key); req_secure = sec;
        req_tag = TAG_W'(tag); req_data = DATA_W'(data);
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready === 1'b0, "R1", "ready_busy", req_ready, 0);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1", "single_rsp", rsp_valid, 0);
    endtask

    // Monitor: pop and compare
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1", "unexpected_rsp", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_data === e.data, e.rq, "data", rsp_data, e.data);
                chk(rsp_poison === e.poison, e.rq, "poison", rsp_poison, e.poison);
                chk(rsp_err === e.err, e.rq, "err", rsp_err, e.err);
                chk(rsp_mce === e.mce, e.rq, "mce", rsp_mce, e.mce);
                chk(int'(err_count) == e.cnt, e.rq, "err_count", err_count, e.cnt);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_own[i] = 0; m_key[i] = 0; m_tag[i] = 0; m_pois[i] = 0; m_errf[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(rsp_valid === 1'b0, "R12", "rsp_valid_reset", rsp_valid, 0);
        chk(err_count === '0, "R12", "err_count_reset", err_count, 0);
        rst_n = 1;
        @(negedge clk);
        // R12: fresh line reads as shared with tag 0
        do_req(0, 0, 15, 1, 1, 0, 32'h1111_0001, "R12");

        // R5 / R3: private write, good read, bad tag poisons
        cfg_mode = 0;
        do_req(1, 1, 0, 40, 1, 28'hA0A0A0, 0, "R3");
        do_req(0, 0, 0, 40, 1, 28'hA0A0A0, 32'hDEAD_0001, "R5");
        do_req(0, 0, 0, 40, 1, 28'h0B0B0B, 32'hDEAD_0002, "R5");
        // R8: sticky poison, partial write keeps it
        do_req(0, 0, 0, 40, 1, 28'hA0A0A0, 32'hDEAD_0003, "R8");
        do_req(1, 0, 0, 40, 1, 28'hA0A0A0, 0, "R8");
        do_req(0, 0, 0, 40, 1, 28'hA0A0A0, 32'hDEAD_0004, "R8");
        do_req(1, 1, 0, 40, 1, 28'hA0A0A0, 0, "R3");
        do_req(0, 0, 0, 40, 1, 28'hA0A0A0, 32'hDEAD_0005, "R3");

        // R5: foreign private domain
        do_req(1, 1, 1, 40, 1, 28'h123, 0, "R3");
        do_req(0, 0, 1, 41, 1, 28'h123, 32'hBEEF_0001, "R5");

        // R4: private read of shared-owned line, both modes
        do_req(1, 1, 2, 3, 1, 28'hC, 0, "R3");
        do_req(0, 0, 2, 40, 1, 28'hC, 32'hBEEF_0002, "R4");
        cfg_mode = 1;
        do_req(1, 1, 3, 3, 1, 28'hC, 0, "R3");
        do_req(0, 0, 3, 40, 1, 28'hC, 32'hBEEF_0003, "R4");
        cfg_mode = 0;

        // R6: crypto shared reads
        do_req(1, 1, 4, 5, 1, 28'h44, 0, "R3");
        do_req(0, 0, 4, 5, 1, 28'h44, 32'hCAFE_0001, "R6");
        do_req(0, 0, 4, 5, 1, 28'h45, 32'hCAFE_0002, "R6");
        do_req(1, 1, 5, 40, 1, 28'h55, 0, "R3");
        do_req(0, 0, 5, 3, 1, 28'h55, 32'hCAFE_0003, "R6");

        // R7 / R10: logical shared read of private line
        cfg_mode = 1;
        do_req(1, 1, 6, 40, 1, 28'h66, 0, "R3");
        do_req(0, 0, 6, 3, 1, 28'h66, 32'hF00D_0001, "R7");
        do_req(0, 0, 6, 40, 1, 28'h66, 32'hF00D_0002, "R10");
        do_req(1, 1, 6, 40, 1, 28'h66, 0, "R3");
        do_req(0, 0, 6, 40, 1, 28'h66, 32'hF00D_0003, "R10");
        // R7: logical shared owner 0 ignores tag; R5 logical ignores tag
        do_req(1, 1, 7, 3, 1, 28'h77, 0, "R3");
        do_req(0, 0, 7, 3, 1, 28'h78, 32'hF00D_0004, "R7");
        do_req(1, 1, 8, 40, 1, 28'h88, 0, "R3");
        do_req(0, 0, 8, 40, 1, 28'h89, 32'hF00D_0005, "R5");
        cfg_mode = 0;

        // R9: non-secure reads
        do_req(1, 1, 9, 40, 1, 28'h99, 0, "R3");
        do_req(0, 0, 9, 40, 0, 28'h99, 32'hAB00_0001, "R9");
        do_req(0, 0, 9, 40, 1, 28'h99, 32'hAB00_0002, "R9");
        do_req(0, 0, 7, 3, 0, 28'h77, 32'hAB00_0003, "R9");

        // R2: threshold boundary 31 shared, 32 private
        do_req(1, 1, 10, 31, 1, 28'hAA, 0, "R2");
        do_req(0, 0, 10, 31, 1, 28'hAA, 32'hB000_0001, "R2");
        do_req(1, 1, 11, 32, 1, 28'hBB, 0, "R2");
        do_req(0, 0, 11, 0, 1, 28'hBB, 32'hB000_0002, "R2");
        cfg_priv_base = 6'd31;
        do_req(1, 1, 12, 31, 1, 28'hCC, 0, "R2");
        do_req(0, 0, 12, 31, 1, 28'hCC, 32'hB000_0003, "R2");
        cfg_priv_base = 6'd32;

        // R11: saturation
        cfg_mode = 1;
        do_req(1, 1, 13, 40, 1, 28'hDD, 0, "R3");
        for (int i = 0; i < 16; i++)
            do_req(0, 0, 13, 2, 1, 28'hDD, 32'hC000_0000 + i, "R11");
        cfg_mode = 0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "pending_rsp", exp_q.size(), 0);
        chk(int'(err_count) == 15, "R11", "err_count_final", err_count, 15);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule